// File: doc/BRIEF.md
# Compensated time base divider

The block is a synchronous binary divider for a 32.768 kHz low-speed time base. Each `lsTick` pulse is one edge of that slow clock, sampled in the fast `clk` domain. A 15-stage counter divides the edges down to 1 Hz. Four of its stages act as periodic sources: 128 Hz, 32 Hz, 16 Hz and 2 Hz. Each source drives a one-cycle tick pulse and a sticky interrupt request.

Software writes a signed trim code. Over every correction window of `2^WIN_LOG2` edges, the block adds or drops one edge for each unit of the code. With the defaults (11-bit code, 2^21-edge window), one step is about 0.48 ppm and the reach is about ±488 ppm. The added or dropped edges are spread evenly through the window by an accumulator. A write to the code takes hold only when the next window begins.

Two capture channels freeze the eight stages from 4096 Hz down to 32 Hz when an external event arrives, and each raises a done flag. A small register port gives access to the trim code, the flags, the capture values and the live count.

Top module: `comp_timebase`

## Requirements
- R1: After reset the counter, trim code, interrupt flags, capture values and done flags all read 0, and no tick pulse is active.
- R2: With no correction pending, each cycle with `lsTick` high adds exactly 1 to the counter. Cycles with `lsTick` low leave the counter unchanged.
- R3: The trim code is a `TRIM_W`-bit two's-complement value written at address 0 and read back sign-extended. Over one full window of `2^WIN_LOG2` ticks, the counter advances by `2^WIN_LOG2 + trim`. A positive code adds edges (a step of 2), and a negative code drops edges (a step of 0).
- R4: Corrections are spread evenly. When |trim| divides the window, the first correction lands on tick `2^WIN_LOG2/|trim|` of the window and the corrections repeat at that spacing.
- R5: A window starts on the first tick after reset and then every `2^WIN_LOG2` ticks. A trim written before a window's first tick applies to that whole window, and a write made mid-window does not alter the current window.
- R6: Flag bits 0..3 at address 1 belong to counter bits 7, 9, 10 and 13 (128, 32, 16 and 2 Hz). When such a bit goes from 0 to 1, `tickOut` for that source pulses for one cycle and the flag is set on the following clock edge.
- R7: Writing 1 to a flag bit clears it, and writing 0 has no effect. If a set and a clear fall on the same edge, the flag stays set.
- R8: A pulse on `capEvt[i]` copies counter bits 9..2 into capture register i (address 2 for channel 0, address 3 for channel 1) and sets done bit i at address 4. If a tick falls on the same edge, the value captured is the count before that tick.
- R9: Done bits at address 4 clear when 1 is written to them. Writing 0 has no effect.
- R10: Address 5 reads the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lsTick | input | 1 | One pulse per low-speed input edge |
| capEvt | input | 2 | Capture event pulses, one per channel |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | TRIM_W | Register write data |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | RD_W | Register read data (combinational) |
| tickOut | output | 4 | One-cycle tick pulses for 128, 32, 16 and 2 Hz |
| irqReq | output | 4 | Sticky interrupt requests, same order as tickOut |

## Verification
The bench targets the window arithmetic, using each trim code's full-window advance and a trim written halfway through a window. A design that loaded the trim at once, or reset the accumulator at the wrong tick, would be off by the old or new code. Spacing checks at ticks 8, 16 and 128 catch corrections that are bunched at the start or the end of a window. The bench also drives a flag clear into the same edge as a set, and a capture into the same edge as a tick. A design with the wrong priority would lose the interrupt, or would capture the count after the tick.

// File: rtl/comp_timebase_pkg.sv
package comp_timebase_pkg;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic step;      // a low-speed edge is present this cycle
    logic addEdge;   // count this edge twice
    logic dropEdge;  // swallow this edge
  } corrStrobe_t;

  localparam int NUM_IRQ = 4;
  localparam int NUM_CAP = 2;
  localparam int CAP_W   = 8;

  localparam int ADDR_TRIM  = 0;
  localparam int ADDR_FLAG  = 1;
  localparam int ADDR_CAP0  = 2;
  localparam int ADDR_CAP1  = 3;
  localparam int ADDR_CAPST = 4;
  localparam int ADDR_COUNT = 5;

  // Counter bit that toggles at each interrupt source's rate.
  function automatic int tapBit(int divW, int idx);
    case (idx)
      0:       return divW - 8;  // 128 Hz
      1:       return divW - 6;  // 32 Hz
      2:       return divW - 5;  // 16 Hz
      default: return divW - 2;  // 2 Hz
    endcase
  endfunction

  // Lowest counter bit held by a capture register (4096 Hz stage).
  function automatic int capLow(int divW);
    return divW - 13;
  endfunction

endpackage

// File: rtl/comp_timebase_ctrl.sv
module comp_timebase_ctrl
  import comp_timebase_pkg::*;
#(
  parameter int TRIM_W   = 11,
  parameter int WIN_LOG2 = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lsTick,
  input  logic              trimWr,
  input  logic [TRIM_W-1:0] trimWrData,
  output logic [TRIM_W-1:0] trimShadow,
  output corrStrobe_t       strobe
);

  localparam int ACC_W = WIN_LOG2 + 1;

  logic [WIN_LOG2-1:0] winCnt;
  logic [WIN_LOG2-1:0] accQ;
  logic [TRIM_W-1:0]   trimActive;
  logic                winStart;
  logic [TRIM_W-1:0]   effTrim;
  logic                trimNeg;
  logic [TRIM_W-1:0]   trimMag;
  logic [WIN_LOG2-1:0] accBase;
  logic [ACC_W-1:0]    accSum;
  logic                corrDue;

  // A window opens on the tick seen while the window counter is zero.
  assign winStart = lsTick && (winCnt == '0);
  assign effTrim  = winStart ? trimShadow : trimActive;
  assign trimNeg  = effTrim[TRIM_W-1];
  assign trimMag  = trimNeg ? (~effTrim + TRIM_W'(1)) : effTrim;
  assign accBase  = winStart ? '0 : accQ;
  assign accSum   = {1'b0, accBase} + ACC_W'(trimMag);
  assign corrDue  = accSum[WIN_LOG2];

  always_comb begin
    strobe.step     = lsTick;
    strobe.addEdge  = lsTick && corrDue && !trimNeg;
    strobe.dropEdge = lsTick && corrDue && trimNeg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt     <= '0;
      accQ       <= '0;
      trimActive <= '0;
      trimShadow <= '0;
    end else begin
      if (trimWr) trimShadow <= trimWrData;
      if (lsTick) begin
        winCnt <= winCnt + WIN_LOG2'(1);
        accQ   <= accSum[WIN_LOG2-1:0];
        if (winStart) trimActive <= trimShadow;
      end
    end
  end

  // R5: the active trim changes only at a window start
  p_active_hold_r5 : assert property (@(posedge clk) disable iff (!rstN)
    !winStart |=> $stable(trimActive));

  // R5: a window start adopts the code software last wrote
  p_window_load_r5 : assert property (@(posedge clk) disable iff (!rstN)
    winStart |=> trimActive == $past(trimShadow));

  // R3: a correction never comes without a low-speed edge
  p_corr_needs_tick_r3 : assert property (@(posedge clk) disable iff (!rstN)
    !lsTick |-> !(strobe.addEdge || strobe.dropEdge));

endmodule

// File: rtl/comp_timebase_dp.sv
module comp_timebase_dp
  import comp_timebase_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  corrStrobe_t                    strobe,
  input  logic [NUM_CAP-1:0]             capEvt,
  input  logic [NUM_IRQ-1:0]             flagClr,
  input  logic [NUM_CAP-1:0]             capClr,
  output logic [DIV_W-1:0]               divQ,
  output logic [NUM_IRQ-1:0]             tickOut,
  output logic [NUM_IRQ-1:0]             irqFlags,
  output logic [NUM_CAP-1:0][CAP_W-1:0]  capHold,
  output logic [NUM_CAP-1:0]             capDone
);

  localparam int CAP_LO = capLow(DIV_W);

  logic [1:0]         stepAmt;
  logic [NUM_IRQ-1:0] tapNow;
  logic [NUM_IRQ-1:0] tapPrev;

  always_comb begin
    if (!strobe.step)        stepAmt = 2'd0;
    else if (strobe.addEdge) stepAmt = 2'd2;
    else if (strobe.dropEdge) stepAmt = 2'd0;
    else                     stepAmt = 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divQ <= '0;
    else       divQ <= divQ + DIV_W'(stepAmt);
  end

  // Interrupt sources: one rising-edge detector and sticky flag each.
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_tap
    localparam int TB = tapBit(DIV_W, i);
    assign tapNow[i]  = divQ[TB];
    assign tickOut[i] = tapNow[i] & ~tapPrev[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tapPrev[i]  <= 1'b0;
        irqFlags[i] <= 1'b0;
      end else begin
        tapPrev[i]  <= tapNow[i];
        irqFlags[i] <= (irqFlags[i] & ~flagClr[i]) | tickOut[i];
      end
    end
  end

  // Capture channels.
  for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capHold[c] <= '0;
        capDone[c] <= 1'b0;
      end else begin
        if (capEvt[c]) capHold[c] <= divQ[CAP_LO +: CAP_W];
        capDone[c] <= (capDone[c] & ~capClr[c]) | capEvt[c];
      end
    end
  end

  // R2: without an edge the counter holds
  p_hold_idle_r2 : assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> $stable(divQ));

  // R2: an uncorrected edge adds exactly one
  p_plain_step_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.addEdge && !strobe.dropEdge) |=> divQ == $past(divQ) + DIV_W'(1));

  // R6: every tick pulse leaves its flag set
  p_flag_set_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (tickOut != '0) |=> ((irqFlags & $past(tickOut)) == $past(tickOut)));

  // R7: a clear with no competing set empties the flag
  p_flag_clear_r7 : assert property (@(posedge clk) disable iff (!rstN)
    ((flagClr & ~tickOut) != '0) |=> ((irqFlags & $past(flagClr & ~tickOut)) == '0));

  // R8: channel 0 holds the stages seen on the event edge
  p_capture_r8 : assert property (@(posedge clk) disable iff (!rstN)
    capEvt[0] |=> (capHold[0] == $past(divQ[CAP_LO +: CAP_W])) && capDone[0]);

endmodule

// File: rtl/comp_timebase.sv
module comp_timebase
  import comp_timebase_pkg::*;
#(
  parameter int  DIV_W    = 15,
  parameter int  TRIM_W   = 11,
  parameter int  WIN_LOG2 = 21,
  parameter int  ADDR_W   = 3,
  localparam int RD_W     = (DIV_W > TRIM_W) ? DIV_W : TRIM_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lsTick,
  input  logic [1:0]         capEvt,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [TRIM_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [RD_W-1:0]    rdData,
  output logic [3:0]         tickOut,
  output logic [3:0]         irqReq
);

  corrStrobe_t                   strobe;
  logic [TRIM_W-1:0]             trimShadow;
  logic                          trimWr;
  logic [NUM_IRQ-1:0]            flagClr;
  logic [NUM_CAP-1:0]            capClr;
  logic [DIV_W-1:0]              divQ;
  logic [NUM_CAP-1:0][CAP_W-1:0] capHold;
  logic [NUM_CAP-1:0]            capDone;

  assign trimWr  = wrEn && (wrAddr == ADDR_W'(ADDR_TRIM));
  assign flagClr = (wrEn && (wrAddr == ADDR_W'(ADDR_FLAG)))  ? wrData[NUM_IRQ-1:0] : '0;
  assign capClr  = (wrEn && (wrAddr == ADDR_W'(ADDR_CAPST))) ? wrData[NUM_CAP-1:0] : '0;

  comp_timebase_ctrl #(
    .TRIM_W   (TRIM_W),
    .WIN_LOG2 (WIN_LOG2)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .lsTick     (lsTick),
    .trimWr     (trimWr),
    .trimWrData (wrData),
    .trimShadow (trimShadow),
    .strobe     (strobe)
  );

  comp_timebase_dp #(
    .DIV_W (DIV_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .capEvt   (capEvt),
    .flagClr  (flagClr),
    .capClr   (capClr),
    .divQ     (divQ),
    .tickOut  (tickOut),
    .irqFlags (irqReq),
    .capHold  (capHold),
    .capDone  (capDone)
  );

  always_comb begin
    case (rdAddr)
      ADDR_W'(ADDR_TRIM):  rdData = RD_W'($signed(trimShadow));
      ADDR_W'(ADDR_FLAG):  rdData = RD_W'(irqReq);
      ADDR_W'(ADDR_CAP0):  rdData = RD_W'(capHold[0]);
      ADDR_W'(ADDR_CAP1):  rdData = RD_W'(capHold[1]);
      ADDR_W'(ADDR_CAPST): rdData = RD_W'(capDone);
      ADDR_W'(ADDR_COUNT): rdData = RD_W'(divQ);
      default:             rdData = '0;
    endcase
  end

endmodule

// File: tb/comp_timebase_tb_top.sv
module comp_timebase_tb_top;

  localparam int DIV_W    = 15;
  localparam int TRIM_W   = 6;
  localparam int WIN_LOG2 = 8;
  localparam int ADDR_W   = 3;
  localparam int RD_W     = 15;
  localparam int WIN      = 256;
  localparam int MOD      = 32768;

  // trim code, expected advance over one full window (R3)
  localparam int VEC[6][2] = '{'{0, 256}, '{31, 287}, '{-32, 224},
                               '{5, 261}, '{-1, 255}, '{1, 257}};

  logic              clk = 1'b0;
  logic              rstN;
  logic              lsTick;
  logic [1:0]        capEvt;
  logic              wrEn;
  logic [ADDR_W-1:0] wrAddr;
  logic [TRIM_W-1:0] wrData;
  logic [ADDR_W-1:0] rdAddr;
  logic [RD_W-1:0]   rdData;
  logic [3:0]        tickOut;
  logic [3:0]        irqReq;

  int nChk  = 0;
  int nFail = 0;
  int expDiv = 0;

  always #4 clk = ~clk;

  comp_timebase #(
    .DIV_W (DIV_W), .TRIM_W (TRIM_W), .WIN_LOG2 (WIN_LOG2), .ADDR_W (ADDR_W)
  ) dut_i (
    .clk (clk), .rstN (rstN), .lsTick (lsTick), .capEvt (capEvt),
    .wrEn (wrEn), .wrAddr (wrAddr), .wrData (wrData),
    .rdAddr (rdAddr), .rdData (rdData), .tickOut (tickOut), .irqReq (irqReq)
  );

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runTicks(int n);
    lsTick = 1'b1;
    repeat (n) @(negedge clk);
    lsTick = 1'b0;
  endtask

  task automatic wr(int a, int d);
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = TRIM_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    rdAddr = ADDR_W'(a);
    #1;
    v = int'(rdData);
  endtask

  task automatic chkDiv(string req);
    int v;
    rd(5, v);
    chk(req, v, expDiv % MOD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    int v, prev, d, n;
    rstN = 1'b0; lsTick = 1'b0; capEvt = 2'b00;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 tick reset", int'(tickOut), 0);
    chk("R1 irq reset", int'(irqReq), 0);

    // R2: idle cycles leave the counter alone
    idle(5);
    chkDiv("R2 hold without lsTick");

    // R6: 128 Hz source not early, then a tick pulse at count 128
    runTicks(127); expDiv += 127;
    idle(1);
    rd(1, v);
    chk("R6 no flag before tap", v, 0);
    chkDiv("R2 plain count");
    runTicks(1); expDiv += 1;
    chk("R6 tick pulse 128 Hz", int'(tickOut), 1);
    // R7: clear on the same edge as the set, the set wins
    wr(1, 1);
    rd(1, v);
    chk("R7 set beats clear", v, 1);
    wr(1, 0);
    rd(1, v);
    chk("R7 write zero keeps flag", v, 1);
    wr(1, 1);
    rd(1, v);
    chk("R7 write one clears", v, 0);

    runTicks(384); expDiv += 384;
    idle(1);
    rd(1, v);
    chk("R6 flags at 512", v, 3);
    wr(1, 15);
    runTicks(511); expDiv += 511;
    idle(1);
    rd(1, v);
    chk("R6 16 Hz not yet", (v >> 2) & 1, 0);
    runTicks(1); expDiv += 1;
    idle(1);
    rd(1, v);
    chk("R6 16 Hz set at 1024", (v >> 2) & 1, 1);
    runTicks(7168); expDiv += 7168;
    chk("R6 only 2 Hz pulses at 8192", int'(tickOut), 8);
    idle(1);
    chk("R6 all flags", int'(irqReq), 15);
    chkDiv("R10 live count");
    wr(1, 15);

    // R3 and R5: table of trim codes, one window old code, one window new
    prev = 0;
    for (int k = 0; k < 6; k++) begin
      runTicks(128);
      wr(0, VEC[k][0]);
      rd(0, v);
      chk("R3 trim readback", v, VEC[k][0] & 32'h7FFF);
      runTicks(128);
      expDiv += WIN + prev;
      chkDiv("R5 mid-window write deferred");
      runTicks(256);
      expDiv += VEC[k][1];
      chkDiv("R3 window advance");
      prev = VEC[k][0];
    end

    // R4: even spacing; a write at the boundary applies to the new window
    wr(0, -32);
    runTicks(8);   expDiv += 7;
    chkDiv("R4 first drop on tick 8");
    runTicks(120); expDiv += 105;
    chkDiv("R4 half window -32");
    runTicks(128); expDiv += 112;
    chkDiv("R4 full window -32");
    wr(0, 16);
    runTicks(15);  expDiv += 15;
    chkDiv("R4 no add before tick 16");
    runTicks(1);   expDiv += 2;
    chkDiv("R4 add on tick 16");

    // R8 and R9: capture channels
    rd(5, d);
    capEvt = 2'b01;
    idle(1);
    capEvt = 2'b00;
    rd(2, v);
    chk("R8 capture channel 0", v, (d >> 2) & 255);
    rd(4, v);
    chk("R8 done channel 0", v, 1);
    idle(10);
    chkDiv("R2 hold during capture");
    runTicks(37);
    rd(5, d);
    expDiv = d;
    capEvt = 2'b11;
    idle(1);
    capEvt = 2'b00;
    rd(2, v);
    chk("R8 capture both ch0", v, (d >> 2) & 255);
    rd(3, v);
    chk("R8 capture both ch1", v, (d >> 2) & 255);
    rd(4, v);
    chk("R8 both done", v, 3);
    wr(4, 2);
    rd(4, v);
    chk("R9 clear done 1", v, 1);
    wr(4, 0);
    rd(4, v);
    chk("R9 write zero keeps done", v, 1);
    wr(4, 1);
    rd(4, v);
    chk("R9 clear done 0", v, 0);

    // R8: capture on the same edge as a tick takes the pre-tick count
    rd(5, d);
    n = ((3 - (d % 4)) + 4) % 4 + 4;
    runTicks(n);
    rd(5, d);
    lsTick = 1'b1; capEvt = 2'b10;
    idle(1);
    lsTick = 1'b0; capEvt = 2'b00;
    rd(3, v);
    chk("R8 capture before tick", v, (d >> 2) & 255);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule